// File: doc/BRIEF.md
# Compare-Value Deadline Timer Channel

This block is one timer channel of a per-core timer. It watches a 64-bit count and raises a level interrupt once that count has reached or passed a programmed 64-bit deadline. A build parameter picks the source of the count. The physical variant uses the incoming system count as it is. The virtual variant subtracts a 64-bit offset from the system count.

Software sees the deadline in two ways. The first is an absolute compare value, written as two 32-bit halves. The second is a signed 32-bit countdown, which is relative to the current count. A control word holds the enable and mask bits, and a read-only status bit that shows whether the deadline has been met.

Changes to the control word, the compare value, the offset or the count take effect on the condition at once. The interrupt line is registered, so it follows the condition one clock edge later.

Top module: `cvt_timer_chan`

## Requirements
- R1: After synchronous reset, the enable and mask bits are 0, the compare value is 0 and `irq` is low.
- R2: Reading the control word (select 0) returns enable in bit 0, mask in bit 1 and status in bit 2. Status is 1 only when the channel is enabled and count >= compare value (unsigned). Status reads 0 while the channel is disabled. A write to bit 2 has no effect.
- R3: `irq` is high exactly when, at the previous clock edge, enable was 1, mask was 0 and count >= compare value. A change of the count is therefore seen on `irq` one edge later.
- R4: Setting enable while the condition already holds raises `irq` at the next edge after the write. Clearing enable drops `irq` at the next edge after the write.
- R5: Select 1 writes and reads compare bits 31:0. Select 2 writes and reads compare bits 63:32. Each write leaves the other half unchanged.
- R6: Reading select 3 returns bits 31:0 of (compare value − count).
- R7: Writing select 3 sets the compare value to count + the written 32-bit value, sign-extended to 64 bits. The count used is the one at the write edge.
- R8: With VIRT_EN=1 the count is system count − offset, and a change of the offset re-evaluates status at once and `irq` one edge later. With VIRT_EN=0 the offset has no effect.
- R9: While mask is 1, `irq` stays low, even when enable is 1 and the condition holds. Status still reports the condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | 64 | System count |
| virt_offset | input | 64 | Offset subtracted from the system count in the virtual variant |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 compare low, 2 compare high, 3 countdown |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
A register write is captured at the clock edge where `reg_wr` is high. Reads are combinational, so they reflect the write at the next sample. Changes of the count or the offset show on reads at the next sample with no edge needed. `irq` lags any state change by exactly one further edge. The bench therefore drives and samples on falling edges. After each write, it first confirms that `irq` still holds its old value, then samples again one cycle later for the new value. This pins every interrupt change to its exact cycle. A second, physical instance shares all inputs with the virtual one, so the effect of the offset is seen directly.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_CMP_LO = 2'd1,
        SEL_CMP_HI = 2'd2,
        SEL_TVAL   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic mask;
        logic enable;
    } ctrl_t;

    localparam int BIT_EN   = 0;
    localparam int BIT_MASK = 1;
    localparam int BIT_STAT = 2;
endpackage

// File: rtl/cvt_count_src.sv
module cvt_count_src #(
    parameter int  CNT_W   = 64,
    parameter bit  VIRT_EN = 1'b1
) (
    input  logic [CNT_W-1:0] sys_count,
    input  logic [CNT_W-1:0] offset,
    output logic [CNT_W-1:0] count
);
    generate
        if (VIRT_EN) begin : g_virt
            assign count = sys_count - offset;
        end else begin : g_phys
            logic [CNT_W-1:0] unused_off;
            assign unused_off = offset;
            assign count = sys_count;
        end
    endgenerate
endmodule

// File: rtl/cvt_regs.sv
module cvt_regs
    import cvt_pkg::*;
#(
    parameter int REG_W = 32,
    localparam int CNT_W = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             met,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] cmp,
    output logic [REG_W-1:0] rdata
);
    logic [CNT_W-1:0] wdata_sx;
    logic [CNT_W-1:0] remain;

    assign wdata_sx = {{(CNT_W-REG_W){wdata[REG_W-1]}}, wdata};
    assign remain   = cmp - count;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cmp  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    ctrl.enable <= wdata[BIT_EN];
                    ctrl.mask   <= wdata[BIT_MASK];
                end
                SEL_CMP_LO: cmp[REG_W-1:0]     <= wdata;
                SEL_CMP_HI: cmp[CNT_W-1:REG_W] <= wdata;
                SEL_TVAL:   cmp <= count + wdata_sx;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: begin
                rdata[BIT_EN]   = ctrl.enable;
                rdata[BIT_MASK] = ctrl.mask;
                rdata[BIT_STAT] = ctrl.enable & met;
            end
            SEL_CMP_LO: rdata = cmp[REG_W-1:0];
            SEL_CMP_HI: rdata = cmp[CNT_W-1:REG_W];
            SEL_TVAL:   rdata = remain[REG_W-1:0];
            default:    rdata = '0;
        endcase
    end

    // R5: a half write keeps the other half
    p_lo_keeps_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_CMP_LO) |=> $stable(cmp[CNT_W-1:REG_W]));
    p_hi_keeps_lo_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_CMP_HI) |=> $stable(cmp[REG_W-1:0]));
    // R7: countdown write lands relative to the count at the write edge
    p_tval_write_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_TVAL) |=> cmp == $past(count) + $past(wdata_sx));
    // R2: disabled channel never reports status
    p_stat_off_r2: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL && !ctrl.enable) |-> !rdata[BIT_STAT]);
endmodule

// File: rtl/cvt_irq.sv
module cvt_irq
    import cvt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    output logic             met,
    output logic             irq
);
    assign met = (count >= cmp);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= ctrl.enable & ~ctrl.mask & met;
    end

    // R1: interrupt is quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);
    // R4: a disabled channel leaves the line low one edge later
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> !irq);
    // R9: a masked channel leaves the line low one edge later
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl.mask |=> !irq);
    // R3: a met, enabled, unmasked condition raises the line one edge later
    p_fire_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && !ctrl.mask && met) |=> irq);
endmodule

// File: rtl/cvt_timer_chan.sv
module cvt_timer_chan
    import cvt_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter bit VIRT_EN = 1'b1,
    localparam int CNT_W  = 2 * REG_W,
    localparam int SEL_W  = $bits(reg_sel_e)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] sys_count,
    input  logic [CNT_W-1:0] virt_offset,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cmp;
    ctrl_t            ctrl;
    logic             met;

    cvt_count_src #(.CNT_W(CNT_W), .VIRT_EN(VIRT_EN)) u_src (
        .sys_count (sys_count),
        .offset    (virt_offset),
        .count     (count)
    );

    cvt_regs #(.REG_W(REG_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .sel   (reg_sel_e'(reg_sel)),
        .wdata (reg_wdata),
        .count (count),
        .met   (met),
        .ctrl  (ctrl),
        .cmp   (cmp),
        .rdata (reg_rdata)
    );

    cvt_irq #(.CNT_W(CNT_W)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .count (count),
        .cmp   (cmp),
        .met   (met),
        .irq   (irq)
    );
endmodule

// File: tb/tb_cvt_timer_chan.sv
module tb_cvt_timer_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] sys_count = '0;
    logic [63:0] virt_offset = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata_v, rdata_p;
    logic        irq_v, irq_p;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cvt_timer_chan #(.VIRT_EN(1'b1)) dut (
        .clk(clk), .rst(rst), .sys_count(sys_count), .virt_offset(virt_offset),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_v), .irq(irq_v)
    );
    cvt_timer_chan #(.VIRT_EN(1'b0)) dut_p (
        .clk(clk), .rst(rst), .sys_count(sys_count), .virt_offset(virt_offset),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_p), .irq(irq_p)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        check(act == exp, tag, act, exp);
    endtask

    // drive a write at a falling edge; returns at the falling edge after capture
    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = rdata_v;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk_eq("R1 irq after reset", irq_v, 0);
        rd(0, v); chk_eq("R1 ctrl after reset", v, 0);
        rd(1, v); chk_eq("R1 cmp lo after reset", v, 0);
        rd(2, v); chk_eq("R1 cmp hi after reset", v, 0);
    endtask

    task automatic t_halves();
        logic [31:0] v;
        wr(1, 32'h1111_2222);
        rd(1, v); chk_eq("R5 lo written", v, 32'h1111_2222);
        rd(2, v); chk_eq("R5 hi untouched", v, 0);
        wr(2, 32'hA5A5_0001);
        rd(2, v); chk_eq("R5 hi written", v, 32'hA5A5_0001);
        rd(1, v); chk_eq("R5 lo untouched", v, 32'h1111_2222);
    endtask

    task automatic t_status_irq();
        logic [31:0] v;
        wr(2, 0); wr(1, 32'h100);
        sys_count = 64'h80;
        wr(0, 32'h1);
        rd(0, v); chk_eq("R2 status clear below deadline", v, 32'h1);
        tick(); chk_eq("R3 irq low below deadline", irq_v, 0);
        sys_count = 64'h100;
        rd(0, v); chk_eq("R2 status at deadline", v, 32'h5);
        chk_eq("R3 irq lags count by one edge", irq_v, 0);
        tick(); chk_eq("R3 irq high after count reaches", irq_v, 1);
        wr(0, 32'h0);
        chk_eq("R4 irq holds one edge after disable", irq_v, 1);
        rd(0, v); chk_eq("R2 status zero when disabled", v, 0);
        tick(); chk_eq("R4 irq low after disable", irq_v, 0);
        wr(0, 32'h4);
        rd(0, v); chk_eq("R2 status bit write ignored", v, 0);
        tick(); chk_eq("R2 irq stays low after status write", irq_v, 0);
        wr(0, 32'h1);
        chk_eq("R4 irq not yet one edge after enable", irq_v, 0);
        tick(); chk_eq("R4 irq high after enable with met", irq_v, 1);
        sys_count = 64'h1000;
        rd(0, v); chk_eq("R2 status past deadline", v, 32'h5);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(0, 32'h3);
        tick(); chk_eq("R9 masked irq low", irq_v, 0);
        rd(0, v); chk_eq("R9 status visible while masked", v, 32'h7);
        wr(0, 32'h1);
        tick(); chk_eq("R9 unmask raises irq", irq_v, 1);
        wr(0, 32'h0);
    endtask

    task automatic t_tval();
        logic [31:0] v;
        wr(2, 0); wr(1, 32'h10);
        sys_count = 64'h20;
        rd(3, v); chk_eq("R6 countdown negative", v, 32'hFFFF_FFF0);
        sys_count = 64'h1_0000_0000;
        wr(3, 32'hFFFF_FFFF);
        rd(1, v); chk_eq("R7 negative write lo", v, 32'hFFFF_FFFF);
        rd(2, v); chk_eq("R7 negative write hi", v, 0);
        wr(3, 32'h5);
        rd(1, v); chk_eq("R7 positive write lo", v, 32'h5);
        rd(2, v); chk_eq("R7 positive write hi", v, 1);
        rd(3, v); chk_eq("R6 countdown positive", v, 32'h5);
        sys_count = 64'h1_0000_0002;
        rd(3, v); chk_eq("R6 countdown follows count", v, 32'h3);
    endtask

    task automatic t_virtual();
        logic [31:0] v;
        sys_count = 64'h150; virt_offset = 64'h100;
        wr(2, 0); wr(1, 32'h60);
        wr(0, 32'h1);
        rd(0, v); chk_eq("R8 virtual status below", v, 32'h1);
        chk_eq("R8 physical ignores offset", rdata_p, 32'h5);
        tick();
        chk_eq("R8 virtual irq low", irq_v, 0);
        chk_eq("R8 physical irq high", irq_p, 1);
        rd(3, v); chk_eq("R8 virtual countdown", v, 32'h10);
        virt_offset = 64'hF0;
        rd(0, v); chk_eq("R8 offset change re-evaluates status", v, 32'h5);
        chk_eq("R8 irq waits one edge", irq_v, 0);
        tick(); chk_eq("R8 irq after offset change", irq_v, 1);
        wr(0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_halves();
        t_status_irq();
        t_mask();
        t_tval();
        t_virtual();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule